// File: doc/BRIEF.md
# Equalizer Control Register Slave

This block is the control front end of a five-band stereo tone processor. It listens on a two-wire serial bus as a write-only target. SCL and SDA are sampled with the system clock, and the block acknowledges bytes by asserting an open-drain pull-down enable. A host addresses the block and sends a register pointer byte. It then streams one or more setting bytes, and the pointer advances by one after each accepted byte.

Each of the five bands holds a 3-bit boost code and a 3-bit cut code. For each band the block presents a boost step and a cut step in the range 0 to 5, and one register set drives both audio channels. A global defeat flag, set at reset, forces every presented step to zero without erasing the stored codes. When the host clears the flag, the earlier response returns.

Top module: `eq_ctrl_slave`

## Requirements
- R1: The block acknowledges only the address byte 0x84 when `addr_sel_i` is 0, and only 0x86 when it is 1. Any other address byte, including one with the read bit (bit 0) set, gets no acknowledge. After such a byte the block ignores the bus until the next START.
- R2: A write transfer is START, address, pointer byte, one or more data bytes, then STOP. The block pulls SDA low in the ninth clock slot after each accepted byte.
- R3: The first data byte goes to the register named by the pointer byte. Each later data byte in the same transfer goes to the next pointer value.
- R4: Pointer values 0 to 4 select bands 1 to 5. Data bytes sent to pointer values 5 to 255 are acknowledged and change nothing. The pointer stops at 255 and does not wrap to 0.
- R5: In a data byte, bits 6..4 carry the boost code and bits 2..0 carry the cut code. Band n's steps appear at bits [3n+2:3n] of `boost_step_o` and `cut_step_o`, counting n from 0.
- R6: Codes 0 to 4 show as steps 0 to 4. Codes 5, 6 and 7 all show as step 5.
- R7: Bit 7 of a byte written to pointer 0 sets the defeat flag, shown on `defeat_o`. Bit 7 at any other pointer is ignored. While defeat is 1, all steps read 0 and the stored codes are kept, so clearing defeat restores them.
- R8: After reset, defeat is 1 and every band's codes are 0.
- R9: A START at any point, including in the middle of a byte, restarts address reception. The unfinished byte is dropped.
- R10: A register changes only after all eight bits of its data byte have been received. A STOP in the middle of a byte leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Address strap: 0 selects 0x84, 1 selects 0x86 |
| sda_oe_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| defeat_o | output | 1 | Global defeat flag |
| boost_step_o | output | 15 | Boost step per band, 3 bits each |
| cut_step_o | output | 15 | Cut step per band, 3 bits each |

## Verification
Data bursts with different code patterns check the field positions and saturation. Because every band receives a different boost/cut pair, a swapped field or an off-by-one pointer shows up. Bursts that start at pointer 4 and at pointer 254 run past the band range; they separate discarding from wrapping and from writing into a band. Defeat is set, cleared and then written at a non-zero pointer, which shows whether the stored codes survive and whether bit 7 is decoded only at pointer 0. Wrong addresses, a read address, a restart in the middle of a byte and a stop in the middle of a byte show that only complete, addressed bytes reach the registers.

// File: rtl/eqc_pkg.sv
// Shared widths and types for the equalizer control slave.
package eqc_pkg;
    localparam int unsigned STEP_W   = 3;
    localparam int unsigned MAX_STEP = 5;
    localparam int unsigned BYTE_W   = 8;

    // Stored codes of one band
    typedef struct packed {
        logic [STEP_W-1:0] boost;
        logic [STEP_W-1:0] cut;
    } band_cfg_t;

    // Receive phase of the byte engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/eqc_bus_sampler.sv
// Synchronizes SCL/SDA into the clock domain and flags clock edges and
// START/STOP conditions. Assumes the bus is much slower than clk.
module eqc_bus_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0]                  raw;
    logic [LINES-1:0][SYNC_STAGES-1:0] chain;
    logic [LINES-1:0]                  cur;
    logic [LINES-1:0]                  prev;

    assign raw = {scl_i, sda_i};

    // Synchronizer chains, reset to the idle-high bus level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            for (int k = 0; k < int'(LINES); k++) begin
                chain[k] <= {chain[k][SYNC_STAGES-2:0], raw[k]};
            end
        end
    end

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= cur;
    end

    // Pick the last stage of each chain
    always_comb begin
        for (int k = 0; k < int'(LINES); k++) cur[k] = chain[k][SYNC_STAGES-1];
    end

    assign scl_lvl   = cur[1];
    assign sda_lvl   = cur[0];
    assign scl_rise  = cur[1] & ~prev[1];
    assign scl_fall  = ~cur[1] & prev[1];
    assign start_det = cur[1] & prev[1] & prev[0] & ~cur[0];
    assign stop_det  = cur[1] & prev[1] & ~prev[0] & cur[0];
endmodule

// File: rtl/eqc_byte_engine.sv
// Shifts in bytes, matches the target address, holds the auto-incrementing
// register pointer and issues one write strobe per accepted data byte.
// Assumes the edge and condition strobes come from eqc_bus_sampler.
module eqc_byte_engine #(
    parameter logic [5:0] ADDR_HI = 6'b100001
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_lvl,
    input  logic                         sda_lvl,
    input  logic                         scl_rise,
    input  logic                         scl_fall,
    input  logic                         start_det,
    input  logic                         stop_det,
    input  logic                         addr_sel,
    output logic                         sda_oe,
    output logic                         wr_en,
    output logic [eqc_pkg::BYTE_W-1:0]   wr_ptr,
    output logic                         wr_def,
    output logic [eqc_pkg::STEP_W-1:0]   wr_boost,
    output logic [eqc_pkg::STEP_W-1:0]   wr_cut
);
    import eqc_pkg::*;

    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] PTR_MAX = '1;

    phase_t              phase;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   ptr;
    logic [BYTE_W-1:0]   own_addr;
    logic                byte_done;
    logic                active;

    assign own_addr  = {ADDR_HI, addr_sel, 1'b0};
    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign active    = (phase != PH_IDLE) && (phase != PH_SKIP);

    // Receive state machine: bit shifting, acknowledge and pointer handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_ptr   <= '0;
            wr_def   <= 1'b0;
            wr_boost <= '0;
            wr_cut   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (active) begin
                if (scl_rise && !sda_oe && !byte_done) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end else if (scl_fall) begin
                    if (sda_oe) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end else if (byte_done) begin
                        unique case (phase)
                            PH_ADDR: begin
                                if (shreg == own_addr) begin
                                    phase  <= PH_PTR;
                                    sda_oe <= 1'b1;
                                end else begin
                                    phase  <= PH_SKIP;
                                end
                            end
                            PH_PTR: begin
                                ptr    <= shreg;
                                phase  <= PH_DATA;
                                sda_oe <= 1'b1;
                            end
                            PH_DATA: begin
                                wr_en    <= 1'b1;
                                wr_ptr   <= ptr;
                                wr_def   <= shreg[7];
                                wr_boost <= shreg[6:4];
                                wr_cut   <= shreg[2:0];
                                sda_oe   <= 1'b1;
                                if (ptr != PTR_MAX) ptr <= ptr + BYTE_W'(1);
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    // R1: a rejected address never produces an acknowledge
    a_r1_no_ack_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !sda_oe);

    // R2: the acknowledge driver only moves while SCL is low
    a_r2_ack_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R4: the pointer saturates instead of wrapping
    a_r4_ptr_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && $past(phase) == PH_DATA && $past(ptr) == PTR_MAX) |-> (ptr == PTR_MAX));

    // R10: a write strobe follows only a complete byte
    a_r10_write_after_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(bit_cnt) == CNT_W'(BYTE_W)));
endmodule

// File: rtl/eqc_band_regs.sv
// Holds the stored boost/cut codes per band and the defeat flag.
// Assumes one write strobe per accepted data byte.
module eqc_band_regs #(
    parameter int unsigned NBANDS = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [eqc_pkg::BYTE_W-1:0]             wr_ptr,
    input  logic                                   wr_def,
    input  logic [eqc_pkg::STEP_W-1:0]             wr_boost,
    input  logic [eqc_pkg::STEP_W-1:0]             wr_cut,
    output eqc_pkg::band_cfg_t [NBANDS-1:0]        cfg_o,
    output logic                                   defeat_o
);
    import eqc_pkg::*;

    band_cfg_t [NBANDS-1:0] cfg_q;
    logic                   defeat_q;

    // Band code storage, selected by pointer value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(NBANDS); i++) begin
                if (wr_ptr == BYTE_W'(i)) begin
                    cfg_q[i].boost <= wr_boost;
                    cfg_q[i].cut   <= wr_cut;
                end
            end
        end
    end

    // Defeat flag, set at reset and written only through pointer 0
    always_ff @(posedge clk) begin
        if (!rst_n)                      defeat_q <= 1'b1;
        else if (wr_en && wr_ptr == '0)  defeat_q <= wr_def;
    end

    assign cfg_o    = cfg_q;
    assign defeat_o = defeat_q;

    // R8: defeat is set when reset is released
    a_r8_defeat_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> defeat_q);

    // R4: writes beyond the band range leave all state untouched
    a_r4_high_ptr_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr >= BYTE_W'(NBANDS)) |=> ($stable(cfg_q) && $stable(defeat_q)));
endmodule

// File: rtl/eqc_step_decode.sv
// Turns a stored 3-bit code into a presented step: saturates at MAX_STEP
// and forces zero while defeated. Purely combinational.
module eqc_step_decode #(
    parameter int unsigned STEP_W   = 3,
    parameter int unsigned MAX_STEP = 5
) (
    input  logic [STEP_W-1:0] code_i,
    input  logic              force_zero_i,
    output logic [STEP_W-1:0] step_o
);
    logic [STEP_W-1:0] sat;

    if (MAX_STEP < (2 ** STEP_W) - 1) begin : g_sat
        // Clamp codes above the top step
        always_comb sat = (code_i > STEP_W'(MAX_STEP)) ? STEP_W'(MAX_STEP) : code_i;
    end else begin : g_pass
        // Every code is a valid step
        always_comb sat = code_i;
    end

    assign step_o = force_zero_i ? '0 : sat;
endmodule

// File: rtl/eq_ctrl_slave.sv
// Top level of the equalizer control slave: bus sampling, byte engine,
// register store and per-band step decoding. Assumes SCL/SDA are
// asynchronous and at least ~10x slower than clk.
module eq_ctrl_slave #(
    parameter int unsigned NBANDS      = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [5:0]  ADDR_HI     = 6'b100001
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 scl_i,
    input  logic                                 sda_i,
    input  logic                                 addr_sel_i,
    output logic                                 sda_oe_o,
    output logic                                 defeat_o,
    output logic [NBANDS*eqc_pkg::STEP_W-1:0]    boost_step_o,
    output logic [NBANDS*eqc_pkg::STEP_W-1:0]    cut_step_o
);
    import eqc_pkg::*;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                   wr_en, wr_def;
    logic [BYTE_W-1:0]      wr_ptr;
    logic [STEP_W-1:0]      wr_boost, wr_cut;
    band_cfg_t [NBANDS-1:0] cfg;
    logic                   defeat;

    eqc_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    eqc_byte_engine #(.ADDR_HI(ADDR_HI)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .addr_sel(addr_sel_i), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_def(wr_def),
        .wr_boost(wr_boost), .wr_cut(wr_cut)
    );

    eqc_band_regs #(.NBANDS(NBANDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_def(wr_def), .wr_boost(wr_boost), .wr_cut(wr_cut),
        .cfg_o(cfg), .defeat_o(defeat)
    );

    assign defeat_o = defeat;

    for (genvar b = 0; b < int'(NBANDS); b++) begin : g_band
        eqc_step_decode #(.STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_boost (
            .code_i(cfg[b].boost), .force_zero_i(defeat),
            .step_o(boost_step_o[b*STEP_W +: STEP_W])
        );
        eqc_step_decode #(.STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_cut (
            .code_i(cfg[b].cut), .force_zero_i(defeat),
            .step_o(cut_step_o[b*STEP_W +: STEP_W])
        );

        // R6: presented steps never exceed the top step
        a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (boost_step_o[b*STEP_W +: STEP_W] <= STEP_W'(MAX_STEP)) &&
            (cut_step_o[b*STEP_W +: STEP_W] <= STEP_W'(MAX_STEP)));
    end

    // R7: defeat zeroes every presented step
    a_r7_defeat_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        defeat_o |-> (boost_step_o == '0 && cut_step_o == '0));
endmodule

// File: tb/eq_ctrl_slave_tb_top.sv
// Scoreboard bench: bus driver tasks push expected acknowledge values,
// a bus monitor pops them at each ninth clock slot; register outputs
// are compared against a model built from the requirements.
module eq_ctrl_slave_tb_top;
    localparam int NB = 5;
    localparam int H  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic strap = 1'b1;
    logic sda_oe, defeat;
    logic [NB*3-1:0] boost_s, cut_s;
    wire  sda_bus = ~(m_low | sda_oe);

    int n_checks = 0;
    int n_fail = 0;
    bit exp_q[$];
    int mb[NB];
    int mc[NB];
    bit md;

    always #5 clk = ~clk;

    eq_ctrl_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel_i(strap), .sda_oe_o(sda_oe), .defeat_o(defeat),
        .boost_step_o(boost_s), .cut_step_o(cut_s)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        hp(); m_low = 1'b0; hp(); scl_m = 1'b1; hp(); m_low = 1'b1; hp(); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        hp(); m_low = 1'b1; hp(); scl_m = 1'b1; hp(); m_low = 1'b0; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            hp(); m_low = ~b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack);
        exp_q.push_back(exp_ack);
        send_bits(b, 8);
        hp(); m_low = 1'b0; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] adr, input logic [7:0] ptr,
                        input logic [7:0] d[4], input int n, input bit ack);
        bus_start();
        send_byte(adr, ack);
        if (ack) begin
            send_byte(ptr, 1'b1);
            for (int i = 0; i < n; i++) send_byte(d[i], 1'b1);
        end
        bus_stop();
        repeat (10) @(negedge clk);
    endtask

    // Model of one register write, from R4, R5 and R7
    task automatic mdl_write(input int ptr, input logic [7:0] b);
        if (ptr < NB) begin
            mb[ptr] = int'(b[6:4]);
            mc[ptr] = int'(b[2:0]);
        end
        if (ptr == 0) md = b[7];
    endtask

    // Compare all outputs with the model (R6 saturation, R7 defeat)
    task automatic check_all(input string tag);
        chk(defeat == md, {tag, " defeat"}, int'(defeat), int'(md));
        for (int b = 0; b < NB; b++) begin
            int eb, ec;
            eb = md ? 0 : (mb[b] > 5 ? 5 : mb[b]);
            ec = md ? 0 : (mc[b] > 5 ? 5 : mc[b]);
            chk(int'(boost_s[b*3 +: 3]) == eb, $sformatf("%s boost band%0d", tag, b + 1),
                int'(boost_s[b*3 +: 3]), eb);
            chk(int'(cut_s[b*3 +: 3]) == ec, $sformatf("%s cut band%0d", tag, b + 1),
                int'(cut_s[b*3 +: 3]), ec);
        end
    endtask

    // Monitor: counts SCL rises since START/STOP, compares each ninth slot (R2)
    initial begin
        logic ps, pd;
        int cnt;
        ps = 1'b1; pd = 1'b1; cnt = 0;
        forever begin
            @(scl_m or sda_bus);
            if (scl_m && !ps) begin
                cnt++;
                if (cnt == 9) begin
                    bit act, e;
                    act = (sda_bus === 1'b0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected ack slot", int'(act), 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(act == e, "R2 R1 ack slot", int'(act), int'(e));
                    end
                    cnt = 0;
                end
            end else if (scl_m && ps && sda_bus !== pd) begin
                cnt = 0;
            end
            ps = scl_m;
            pd = sda_bus;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d[4];
        for (int i = 0; i < NB; i++) begin mb[i] = 0; mc[i] = 0; end
        md = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R8 no pull-down after reset", int'(sda_oe), 0);
        check_all("R8 reset");

        d = '{8'h00, 8'h00, 8'h00, 8'h00};
        xfer(8'h86, 8'h00, d, 1, 1'b1); mdl_write(0, 8'h00);
        check_all("R8 R2 bands zero, defeat cleared");

        // R3 R5 R6: distinct pair per band, saturating codes
        d = '{8'h12, 8'h34, 8'h43, 8'h70};
        xfer(8'h86, 8'h00, d, 4, 1'b1);
        for (int i = 0; i < 4; i++) mdl_write(i, d[i]);
        d = '{8'h07, 8'h00, 8'h00, 8'h00};
        xfer(8'h86, 8'h04, d, 1, 1'b1); mdl_write(4, 8'h07);
        check_all("R3 R5 R6 burst");

        d = '{8'h11, 8'h55, 8'h66, 8'h00};
        xfer(8'h86, 8'h04, d, 3, 1'b1); mdl_write(4, 8'h11);
        check_all("R4 beyond band range discarded");

        d = '{8'h77, 8'h77, 8'h77, 8'h00};
        xfer(8'h86, 8'hFE, d, 3, 1'b1);
        check_all("R4 pointer no wrap");

        d = '{8'hA1, 8'h00, 8'h00, 8'h00};
        xfer(8'h86, 8'h00, d, 1, 1'b1); mdl_write(0, 8'hA1);
        check_all("R7 defeat forces zero");
        d = '{8'h21, 8'h00, 8'h00, 8'h00};
        xfer(8'h86, 8'h00, d, 1, 1'b1); mdl_write(0, 8'h21);
        check_all("R7 settings restored");
        d = '{8'hA4, 8'h00, 8'h00, 8'h00};
        xfer(8'h86, 8'h02, d, 1, 1'b1); mdl_write(2, 8'h24);
        check_all("R7 bit7 ignored off pointer 0");

        strap = 1'b0;
        d = '{8'h55, 8'h00, 8'h00, 8'h00};
        xfer(8'h86, 8'h03, d, 1, 1'b0);
        check_all("R1 strap low rejects 0x86");
        xfer(8'h84, 8'h03, d, 1, 1'b1); mdl_write(3, 8'h55);
        check_all("R1 strap low accepts 0x84");
        xfer(8'h85, 8'h01, d, 1, 1'b0);
        check_all("R1 read address rejected");
        strap = 1'b1;
        xfer(8'h84, 8'h01, d, 1, 1'b0);
        check_all("R1 strap high rejects 0x84");

        // R9: restart in the middle of a data byte
        bus_start();
        send_byte(8'h86, 1'b1);
        send_byte(8'h01, 1'b1);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'h86, 1'b1);
        send_byte(8'h03, 1'b1);
        send_byte(8'h22, 1'b1);
        bus_stop();
        repeat (10) @(negedge clk);
        mdl_write(3, 8'h22);
        check_all("R9 restart mid byte");

        // R10: stop in the middle of a data byte
        bus_start();
        send_byte(8'h86, 1'b1);
        send_byte(8'h00, 1'b1);
        send_bits(8'h33, 5);
        bus_stop();
        repeat (10) @(negedge clk);
        check_all("R10 partial byte dropped");

        chk(exp_q.size() == 0, "R2 all ack slots seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule